// File: doc/BRIEF.md
# POCSAG Codeword Address Matcher

This block receives a paging bit stream that an external clock-recovery stage has already sliced into bits. Each recovered bit comes with a one-cycle strobe. The block looks for the batch synchronisation word, counts codeword slots inside each batch and checks every codeword for errors. It then compares each address codeword against six programmable receiver addresses. When an enabled address matches, the block emits a header byte and raises an interrupt. Each message codeword that follows is emitted as one tag byte and three payload bytes, until an end-of-message condition occurs.

Configuration is written once through a three-wire serial load port: a shift clock, a data line and a clear line. Decoding starts when the enable line falls after a complete load. The data rate is set entirely by how often the bit strobe fires, so 512, 1200 and 2400 bit/s streams all use the same logic.

Top module: `pocsag_addr_match`

## Requirements
- R1: After reset, and whenever decoding is not running, `byte_vld` and `irq` stay low.
- R2: Each rising edge of `opt_clk` shifts `opt_dat` into a 192-bit chain, so the first bit sent ends at position 191. Field positions in the final chain are as follows. Address slot k (k = 0..5) is held in bits [21k+20 : 21k], and its enable is bit 126+k. The end-of-message rule is bit 132 and the data inversion flag is bit 133. Bits 134..136 are test bits and bits 137..191 are reserved. Driving `opt_rst` high clears the chain and stops decoding.
- R3: Decoding starts only on a high-to-low transition of `dec_en` after at least 192 load bits have arrived since the last clear. A falling edge that comes after a shorter load has no effect.
- R4: A batch begins on an exact match of the 32-bit window with 0x7CD215D8. Sixteen codeword slots follow, and the frame index of a slot is the slot number divided by two. If the 32 bits after slot 15 are not the sync word, the block goes back to hunting and ends any message in progress.
- R5: An address codeword is a valid codeword with bit 31 = 0 that is not the idle word 0x7A89C197. The value compared is {cw[30:13], frame index}. Only enabled slots can match, and when several slots match the lowest-numbered one wins.
- R6: The header byte is {slot index[7:5], 0 at bit 4, cw[12:11] at bits 3:2, 00}. `irq` pulses for one cycle, in the cycle after `byte_vld` presents that header.
- R7: Each accepted message codeword (bit 31 = 1) emits four bytes in order. The first is a tag {slot index, 1, uncorrectable flag, 000}. The next three are cw[30:23], cw[22:15] and {cw[14:11], 0000}.
- R8: A codeword counts as uncorrectable when the remainder of cw[31:1] modulo the generator 0x769 is nonzero, or when the 32 bits have odd parity.
- R9: With bit 132 = 0, the first uncorrectable codeword ends the message and emits nothing. With bit 132 = 1, a single uncorrectable codeword is emitted with its flag set, and a second one in a row ends the message. The idle word, or any address codeword, also ends the message.
- R10: With bit 133 = 1, every received bit is inverted before any other processing.
- R11: The values of the test bits 134..136 have no effect on decoding.
- R12: Queued bytes leave one per bit strobe, in the cycle after that strobe. Behaviour does not depend on how far apart the strobes are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | One-cycle strobe marking a recovered bit |
| bit_in | input | 1 | Recovered NRZ bit, most significant bit of a codeword first |
| opt_clk | input | 1 | Option load shift clock (rising edge shifts) |
| opt_dat | input | 1 | Option load serial data |
| opt_rst | input | 1 | Clears the option chain and stops decoding |
| dec_en | input | 1 | Falling edge starts decoding after a full load |
| byte_vld | output | 1 | Output byte valid, one cycle |
| byte_out | output | 8 | Header, tag or payload byte |
| irq | output | 1 | Address match interrupt pulse |

## Verification
Two functions can act on the same codeword: ending a running message and starting a new one. This happens when an address codeword arrives directly after a message codeword. The bench provokes it by sending, in back-to-back slots, a matching address, a message word, and then a second matching address for a different slot. It expects an unbroken byte stream: the first header, four message bytes, then the second header with the new index, with exactly two interrupts and no byte lost or repeated. A separate test sends an uncorrectable word followed by a good one under each end rule, to show which byte group the end decision removes.

// File: rtl/pocsag_pkg.sv
package pocsag_pkg;

    localparam int CW_W      = 32;
    localparam int NUM_SLOTS = 6;
    localparam int IDX_W     = $clog2(NUM_SLOTS);
    localparam int ADDR_W    = 21;
    localparam int FRAME_W   = 3;
    localparam int BATCH_CW  = 16;
    localparam int OPT_LEN   = 192;
    localparam int OPT_EN_LSB = NUM_SLOTS * ADDR_W;
    localparam int OPT_END2  = OPT_EN_LSB + NUM_SLOTS;
    localparam int OPT_INV   = OPT_END2 + 1;
    localparam int OPT_KEEP  = OPT_INV + 1;
    localparam int BCH_PAR   = 10;

    localparam logic [CW_W-1:0] SYNC_CW = 32'h7CD2_15D8;
    localparam logic [CW_W-1:0] IDLE_CW = 32'h7A89_C197;
    localparam logic [BCH_PAR:0] BCH_POLY = 11'h769;

    typedef struct packed {
        logic [NUM_SLOTS-1:0][ADDR_W-1:0] addr;
        logic [NUM_SLOTS-1:0]             en;
        logic                             end2;
        logic                             inv;
    } cfg_t;

    typedef struct packed {
        logic               vld;
        logic [CW_W-1:0]    data;
        logic [FRAME_W-1:0] frame;
    } cw_evt_t;

    typedef struct packed {
        logic             any;
        logic [IDX_W-1:0] idx;
    } pick_t;

    typedef enum logic [1:0] {FR_HUNT, FR_BATCH, FR_RESYNC} fr_state_e;
    typedef enum logic {RX_IDLE, RX_MSG} rx_state_e;

    // Remainder of the 31-bit code part over the generator plus even parity.
    function automatic logic cw_ok(input logic [CW_W-1:0] cw);
        logic [CW_W-2:0] r;
        r = cw[CW_W-1:1];
        for (int i = CW_W - 2; i >= BCH_PAR; i--) begin
            if (r[i]) r = r ^ ((CW_W-1)'(BCH_POLY) << (i - BCH_PAR));
        end
        return (r[BCH_PAR-1:0] == '0) && !(^cw);
    endfunction

    function automatic pick_t first_hit(input logic [NUM_SLOTS-1:0] hit);
        pick_t p;
        p.any = |hit;
        p.idx = '0;
        for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
            if (hit[k]) p.idx = IDX_W'(k);
        end
        return p;
    endfunction

    function automatic logic [7:0] hdr_byte(input logic [IDX_W-1:0] idx,
                                            input logic [1:0] func);
        return {idx, 1'b0, func, 2'b00};
    endfunction

    function automatic logic [7:0] tag_byte(input logic [IDX_W-1:0] idx,
                                            input logic bad);
        return {idx, 1'b1, bad, 3'b000};
    endfunction

endpackage

// File: rtl/pcw_optload.sv
module pcw_optload
    import pocsag_pkg::*;
#(
    parameter int LEN  = OPT_LEN,
    parameter int KEEP = OPT_KEEP
) (
    input  logic clk,
    input  logic rst,
    input  logic opt_clk,
    input  logic opt_dat,
    input  logic opt_rst,
    input  logic dec_en,
    output cfg_t cfg,
    output logic run
);
    localparam int CNT_W = $clog2(LEN + 1);

    // Only the low KEEP positions carry live fields; earlier bits fall off.
    logic [KEEP-1:0]  chain;
    logic [CNT_W-1:0] cnt;
    logic             clk_q;
    logic             en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            cnt   <= '0;
            clk_q <= 1'b0;
            en_q  <= 1'b0;
            run   <= 1'b0;
        end else begin
            clk_q <= opt_clk;
            en_q  <= dec_en;
            if (opt_rst) begin
                chain <= '0;
                cnt   <= '0;
                run   <= 1'b0;
            end else begin
                if (opt_clk && !clk_q && !run) begin
                    chain <= {chain[KEEP-2:0], opt_dat};
                    if (cnt != CNT_W'(LEN)) cnt <= cnt + 1'b1;
                end
                if (!dec_en && en_q && cnt == CNT_W'(LEN)) run <= 1'b1;
            end
        end
    end

    always_comb begin
        for (int k = 0; k < NUM_SLOTS; k++) begin
            cfg.addr[k] = chain[k*ADDR_W +: ADDR_W];
        end
        cfg.en   = chain[OPT_EN_LSB +: NUM_SLOTS];
        cfg.end2 = chain[OPT_END2];
        cfg.inv  = chain[OPT_INV];
    end

endmodule

// File: rtl/pcw_framer.sv
module pcw_framer
    import pocsag_pkg::*;
#(
    parameter int SLOTS = BATCH_CW
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    run,
    input  logic    bit_vld,
    input  logic    bit_in,
    input  logic    inv,
    output cw_evt_t evt,
    output logic    lost
);
    localparam int BIT_W  = $clog2(CW_W);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(CW_W - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    fr_state_e         st;
    logic [CW_W-1:0]   sr;
    logic [BIT_W-1:0]  bcnt;
    logic [SLOT_W-1:0] slot;
    logic [CW_W-1:0]   win;

    assign win = {sr[CW_W-2:0], bit_in ^ inv};

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            st   <= FR_HUNT;
            sr   <= '0;
            bcnt <= '0;
            slot <= '0;
            evt  <= '0;
            lost <= 1'b0;
        end else begin
            evt.vld <= 1'b0;
            lost    <= 1'b0;
            if (bit_vld) begin
                sr <= win;
                case (st)
                    FR_HUNT: begin
                        if (win == SYNC_CW) begin
                            st   <= FR_BATCH;
                            bcnt <= '0;
                            slot <= '0;
                        end
                    end
                    FR_BATCH: begin
                        bcnt <= bcnt + 1'b1;
                        if (bcnt == LAST_BIT) begin
                            evt.vld   <= 1'b1;
                            evt.data  <= win;
                            evt.frame <= slot[SLOT_W-1:1];
                            if (slot == LAST_SLOT) st <= FR_RESYNC;
                            else slot <= slot + 1'b1;
                        end
                    end
                    FR_RESYNC: begin
                        bcnt <= bcnt + 1'b1;
                        if (bcnt == LAST_BIT) begin
                            slot <= '0;
                            if (win == SYNC_CW) begin
                                st <= FR_BATCH;
                            end else begin
                                st   <= FR_HUNT;
                                lost <= 1'b1;
                            end
                        end
                    end
                    default: st <= FR_HUNT;
                endcase
            end
        end
    end

endmodule

// File: rtl/pcw_msgctl.sv
module pcw_msgctl
    import pocsag_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       bit_vld,
    input  cfg_t       cfg,
    input  cw_evt_t    evt,
    input  logic       lost,
    output logic       byte_vld,
    output logic [7:0] byte_out,
    output logic       irq
);
    localparam int QC_W = $clog2(QDEPTH + 1);

    rx_state_e              state, nstate;
    logic [IDX_W-1:0]       cur_idx, nidx;
    logic                   bad_run, nbad;
    logic [QDEPTH-1:0][7:0] q, lbytes;
    logic [QC_W-1:0]        qcnt, lcnt;
    logic                   q_hdr, lhdr, ld;
    logic                   out_hdr;
    logic                   ok, is_addr;
    logic [NUM_SLOTS-1:0]   hit;
    pick_t                  pick;
    logic [ADDR_W-1:0]      rx_addr;

    assign rx_addr = {evt.data[CW_W-2:13], evt.frame};
    assign ok      = cw_ok(evt.data);
    assign is_addr = ok && !evt.data[CW_W-1] && (evt.data != IDLE_CW);

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_cmp
        assign hit[k] = cfg.en[k] && (cfg.addr[k] == rx_addr);
    end

    assign pick = first_hit(hit);

    always_comb begin
        nstate = state;
        nidx   = cur_idx;
        nbad   = bad_run;
        ld     = 1'b0;
        lbytes = '0;
        lcnt   = '0;
        lhdr   = 1'b0;
        if (evt.vld) begin
            if (is_addr) begin
                nstate = RX_IDLE;
                nbad   = 1'b0;
                if (pick.any) begin
                    nstate    = RX_MSG;
                    nidx      = pick.idx;
                    ld        = 1'b1;
                    lbytes[0] = hdr_byte(pick.idx, evt.data[12:11]);
                    lcnt      = QC_W'(1);
                    lhdr      = 1'b1;
                end
            end else if (state == RX_MSG) begin
                if (evt.data == IDLE_CW) begin
                    nstate = RX_IDLE;
                    nbad   = 1'b0;
                end else if (!ok && (!cfg.end2 || bad_run)) begin
                    nstate = RX_IDLE;
                    nbad   = 1'b0;
                end else begin
                    nbad      = !ok;
                    ld        = 1'b1;
                    lbytes[0] = tag_byte(cur_idx, !ok);
                    lbytes[1] = evt.data[30:23];
                    lbytes[2] = evt.data[22:15];
                    lbytes[3] = {evt.data[14:11], 4'b0000};
                    lcnt      = QC_W'(4);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            state    <= RX_IDLE;
            cur_idx  <= '0;
            bad_run  <= 1'b0;
            q        <= '0;
            qcnt     <= '0;
            q_hdr    <= 1'b0;
            out_hdr  <= 1'b0;
            byte_vld <= 1'b0;
            byte_out <= '0;
            irq      <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            irq      <= byte_vld && out_hdr;
            state    <= lost ? RX_IDLE : nstate;
            cur_idx  <= nidx;
            bad_run  <= lost ? 1'b0 : nbad;
            if (ld) begin
                q     <= lbytes;
                qcnt  <= lcnt;
                q_hdr <= lhdr;
            end else if (bit_vld && qcnt != '0) begin
                byte_vld <= 1'b1;
                byte_out <= q[0];
                out_hdr  <= q_hdr;
                q        <= {8'h00, q[QDEPTH-1:1]};
                qcnt     <= qcnt - 1'b1;
                q_hdr    <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pocsag_addr_match.sv
module pocsag_addr_match
    import pocsag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_vld,
    input  logic       bit_in,
    input  logic       opt_clk,
    input  logic       opt_dat,
    input  logic       opt_rst,
    input  logic       dec_en,
    output logic       byte_vld,
    output logic [7:0] byte_out,
    output logic       irq
);
    cfg_t    cfg;
    logic    run;
    cw_evt_t evt;
    logic    lost;

    pcw_optload u_optload (
        .clk     (clk),
        .rst     (rst),
        .opt_clk (opt_clk),
        .opt_dat (opt_dat),
        .opt_rst (opt_rst),
        .dec_en  (dec_en),
        .cfg     (cfg),
        .run     (run)
    );

    pcw_framer u_framer (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .inv     (cfg.inv),
        .evt     (evt),
        .lost    (lost)
    );

    pcw_msgctl u_msgctl (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .bit_vld  (bit_vld),
        .cfg      (cfg),
        .evt      (evt),
        .lost     (lost),
        .byte_vld (byte_vld),
        .byte_out (byte_out),
        .irq      (irq)
    );

endmodule

// File: rtl/pocsag_addr_match_chk.sv
module pocsag_addr_match_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_vld,
    input logic       opt_rst,
    input logic       run,
    input logic       byte_vld,
    input logic [5:0] hdr_f,
    input logic       irq
);
    // R6
    irq_after_hdr_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(byte_vld) && !$past(hdr_f[2])));

    // R6
    hdr_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(hdr_f[1:0]) == 2'b00));

    // R5
    hdr_index_range_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(hdr_f[5:3]) < 3'd6));

    // R12
    byte_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> $past(bit_vld));

    // R2
    opt_rst_halts_chk: assert property (@(posedge clk) disable iff (rst)
        opt_rst |=> !run);

    // R1
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!byte_vld && !irq));

endmodule

bind pocsag_addr_match pocsag_addr_match_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_vld  (bit_vld),
    .opt_rst  (opt_rst),
    .run      (run),
    .byte_vld (byte_vld),
    .hdr_f    ({byte_out[7:4], byte_out[1:0]}),
    .irq      (irq)
);

// File: tb/pocsag_addr_match_bench.sv
module pocsag_addr_match_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 190000;
    localparam logic [31:0] SYNC = 32'h7CD2_15D8;
    localparam logic [31:0] IDLE = 32'h7A89_C197;
    localparam logic [31:0] FLIP = 32'h0000_0100;

    // {addr18, func2, slot4, hit1, idx3}
    localparam logic [27:0] VEC [0:7] = '{
        {18'h12345, 2'd1, 4'd4,  1'b1, 3'd0},
        {18'h12345, 2'd0, 4'd5,  1'b1, 3'd0},
        {18'h12345, 2'd3, 4'd6,  1'b0, 3'd0},
        {18'h0ABCD, 2'd2, 4'd10, 1'b1, 3'd1},
        {18'h3FFFF, 2'd0, 4'd0,  1'b0, 3'd0},
        {18'h00001, 2'd3, 4'd15, 1'b1, 3'd5},
        {18'h2AAAA, 2'd1, 4'd2,  1'b1, 3'd2},
        {18'h2AAAA, 2'd1, 4'd3,  1'b1, 3'd2}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_vld = 1'b0, bit_in = 1'b0;
    logic       opt_clk = 1'b0, opt_dat = 1'b0, opt_rst = 1'b0, dec_en = 1'b0;
    logic       byte_vld, irq;
    logic [7:0] byte_out;

    int nchk = 0, nerr = 0;
    int nrx = 0, nirq = 0, nexp = 0;
    logic [7:0]  rx [64];
    logic [7:0]  ex [64];
    logic [31:0] bq [16];
    logic        flip = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pocsag_addr_match u_pocsag_addr_match (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
        .opt_clk(opt_clk), .opt_dat(opt_dat), .opt_rst(opt_rst), .dec_en(dec_en),
        .byte_vld(byte_vld), .byte_out(byte_out), .irq(irq)
    );

    always @(negedge clk) begin
        if (byte_vld) begin
            if (nrx < 64) rx[nrx] = byte_out;
            nrx++;
        end
        if (irq) nirq++;
    end

    task automatic chk(input bit good, input string r, input int act, input int exp);
        nchk++;
        if (!good) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    function automatic logic [31:0] enc(input logic [20:0] d);
        logic [30:0] r;
        logic [30:0] c;
        r = {d, 10'b0};
        for (int i = 30; i >= 10; i--) if (r[i]) r = r ^ (31'h769 << (i - 10));
        c = {d, r[9:0]};
        return {c, ^c};
    endfunction

    function automatic logic [31:0] acw(input logic [17:0] a, input logic [1:0] f);
        return enc({1'b0, a, f});
    endfunction

    function automatic logic [31:0] mcw(input logic [19:0] p);
        return enc({1'b1, p});
    endfunction

    function automatic logic [191:0] mk_cfg(input logic e2, input logic iv, input logic [2:0] t);
        logic [191:0] c;
        c = '0;
        c[0   +: 21] = {18'h12345, 3'd2};
        c[21  +: 21] = {18'h0ABCD, 3'd5};
        c[42  +: 21] = {18'h2AAAA, 3'd1};
        c[63  +: 21] = {18'h0ABCD, 3'd5};
        c[84  +: 21] = {18'h3FFFF, 3'd0};
        c[105 +: 21] = {18'h00001, 3'd7};
        c[126 +: 6]  = 6'b101111;
        c[132] = e2;
        c[133] = iv;
        c[134 +: 3] = t;
        return c;
    endfunction

    task automatic load_cfg(input logic [191:0] c, input int nbits);
        @(negedge clk); opt_rst = 1'b1; dec_en = 1'b1;
        @(negedge clk); opt_rst = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            opt_dat = c[191 - i]; opt_clk = 1'b1;
            @(negedge clk); opt_clk = 1'b0;
            @(negedge clk);
        end
        dec_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input int gap);
        bit_in = b ^ flip; bit_vld = 1'b1;
        @(negedge clk); bit_vld = 1'b0;
        repeat (gap - 1) @(negedge clk);
    endtask

    task automatic send_cw(input logic [31:0] cw, input int gap);
        for (int i = 31; i >= 0; i--) send_bit(cw[i], gap);
    endtask

    task automatic idle_fill();
        for (int i = 0; i < 16; i++) bq[i] = IDLE;
    endtask

    task automatic send_batch(input int gap);
        send_cw(SYNC, gap);
        for (int i = 0; i < 16; i++) send_cw(bq[i], gap);
    endtask

    task automatic tail(input int gap);
        for (int i = 0; i < 8; i++) send_bit(1'b0, gap);
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_rx();
        @(negedge clk); nrx = 0; nirq = 0; nexp = 0;
    endtask

    task automatic add_ex(input logic [7:0] b);
        ex[nexp] = b; nexp++;
    endtask

    task automatic add_msg(input logic [2:0] idx, input logic bad, input logic [19:0] p);
        add_ex({idx, 1'b1, bad, 3'b000});
        add_ex(p[19:12]);
        add_ex(p[11:4]);
        add_ex({p[3:0], 4'b0000});
    endtask

    task automatic check_stream(input string r);
        chk(nrx == nexp, {r, " byte count"}, nrx, nexp);
        for (int i = 0; i < nexp && i < nrx; i++)
            chk(rx[i] == ex[i], {r, " byte value"}, rx[i], ex[i]);
    endtask

    task automatic run_vec(input int i, input int gap);
        logic [27:0] v;
        v = VEC[i];
        idle_fill();
        bq[v[7:4]] = acw(v[27:10], v[9:8]);
        send_batch(gap);
        tail(gap);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
        report();
    end

    initial begin
        logic [27:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet after reset
        chk(byte_vld == 1'b0, "R1 byte_vld after reset", byte_vld, 0);
        chk(irq == 1'b0, "R1 irq after reset", irq, 0);

        // R3: short load then enable fall must not start decoding
        load_cfg(mk_cfg(1'b0, 1'b0, 3'b101), 100);
        clear_rx();
        run_vec(0, 2);
        chk(nrx == 0, "R3 short load ignored", nrx, 0);

        // Vector table: R5 matching, R6 header/irq, R12 strobe spacing, R11 test bits set
        load_cfg(mk_cfg(1'b0, 1'b0, 3'b101), 192);
        for (int i = 0; i < 8; i++) begin
            v = VEC[i];
            clear_rx();
            run_vec(i, 1 + (i % 4));
            if (v[3]) begin
                add_ex({v[2:0], 1'b0, v[9:8], 2'b00});
                check_stream("R5 R6 R12 table match");
                chk(nirq == 1, "R6 irq on match", nirq, 1);
            end else begin
                chk(nrx == 0, "R5 table no match", nrx, 0);
                chk(nirq == 0, "R5 no irq", nirq, 0);
            end
        end

        // R7: header plus two message words, then idle ends
        clear_rx(); idle_fill();
        bq[4] = acw(18'h12345, 2'd1);
        bq[5] = mcw(20'hABCDE);
        bq[6] = mcw(20'h13579);
        send_batch(2); tail(2);
        add_ex(8'h04); add_msg(3'd0, 1'b0, 20'hABCDE); add_msg(3'd0, 1'b0, 20'h13579);
        check_stream("R7 message bytes");
        chk(nirq == 1, "R6 single irq", nirq, 1);

        // R9/R8: first uncorrectable ends the message
        clear_rx(); idle_fill();
        bq[4] = acw(18'h12345, 2'd1);
        bq[5] = mcw(20'hABCDE) ^ FLIP;
        bq[6] = mcw(20'h13579);
        send_batch(3); tail(3);
        add_ex(8'h04);
        check_stream("R9 R8 end on first bad");

        // R4: missing sync after slot 15 ends the message
        clear_rx(); idle_fill();
        bq[14] = acw(18'h00001, 2'd2);
        bq[15] = mcw(20'h0F0F0);
        send_batch(2);
        send_cw(mcw(20'h11111), 2);
        send_cw(mcw(20'h22222), 2);
        tail(2);
        add_ex(8'hA8); add_msg(3'd5, 1'b0, 20'h0F0F0);
        check_stream("R4 lost sync");

        // Concurrent end-of-message and new match on one codeword
        clear_rx(); idle_fill();
        bq[2] = acw(18'h2AAAA, 2'd3);
        bq[3] = mcw(20'h55AA5);
        bq[4] = acw(18'h12345, 2'd2);
        bq[5] = mcw(20'hFEDCB);
        send_batch(1); tail(1);
        add_ex(8'h4C); add_msg(3'd2, 1'b0, 20'h55AA5);
        add_ex(8'h08); add_msg(3'd0, 1'b0, 20'hFEDCB);
        check_stream("R5 R9 address ends and restarts");
        chk(nirq == 2, "R6 two irqs", nirq, 2);

        // R9: two-in-a-row rule, R11 with other test bits
        load_cfg(mk_cfg(1'b1, 1'b0, 3'b111), 192);
        clear_rx(); idle_fill();
        bq[4] = acw(18'h12345, 2'd1);
        bq[5] = mcw(20'h10001) ^ FLIP;
        bq[6] = mcw(20'h20002);
        bq[7] = mcw(20'h30003) ^ FLIP;
        bq[8] = mcw(20'h40004) ^ FLIP;
        bq[9] = mcw(20'h50005);
        send_batch(2); tail(2);
        add_ex(8'h04);
        add_msg(3'd0, 1'b1, 20'h10001);
        add_msg(3'd0, 1'b0, 20'h20002);
        add_msg(3'd0, 1'b1, 20'h30003);
        check_stream("R9 R11 end on two bad");

        // R10: inverted stream decoded with inversion on
        load_cfg(mk_cfg(1'b0, 1'b1, 3'b010), 192);
        clear_rx();
        flip = 1'b1;
        run_vec(0, 2);
        add_ex(8'h04);
        check_stream("R10 inverted match");
        clear_rx();
        flip = 1'b0;
        run_vec(0, 2);
        chk(nrx == 0, "R10 plain stream rejected", nrx, 0);

        // R2: clear line stops decoding
        @(negedge clk); opt_rst = 1'b1;
        @(negedge clk); opt_rst = 1'b0;
        clear_rx();
        flip = 1'b1;
        run_vec(0, 2);
        chk(nrx == 0, "R2 cleared no bytes", nrx, 0);
        chk(nirq == 0, "R2 cleared no irq", nirq, 0);

        report();
    end

endmodule